// File: doc/BRIEF.md
# Color-Steering Pixel Gain Sequencer

This block picks, for every pixel of an image sensor readout, one of four programmable 6-bit gain words, following a repeating color pattern. It is clocked by the pixel sample strobe. Frame sync and line sync inputs are sampled only on strobe rising edges. The gain index advances by one per pixel and wraps after three or four colors, depending on the active mode.

The pattern restarts at gain 0 only on a line sync rising edge that comes after a frame sync rising edge. Later line syncs in the same frame leave the pattern running. The mode chosen by the host takes effect only at a restart, so a line never mixes two cycle lengths. Gain words are loaded through a parallel write port. Each pixel's gain word and its index come out of a register, one strobe after the edge that selects them.

Top module: `color_gain_seq`

## Requirements
- R1: While rst_ni is low, gain_o and gain_idx_o are 0. After reset, all four gain words read as 0, no frame sync is pending, and the active mode is 3-color.
- R2: In 3-color mode (active mode 0) the index advances once per strobe edge in the order 0,1,2,0,1,2 and never takes the value 3.
- R3: In 4-color mode (active mode 1) the index advances once per strobe edge in the order 0,1,2,3,0,...
- R4: A line sync rising edge (hd_i 0 at one strobe edge and 1 at the next) restarts the pattern when a frame sync rising edge was seen at an earlier strobe edge. The index for that strobe edge is 0. A frame sync edge at the same strobe edge as the line sync edge does not restart the pattern, but it leaves a pending frame sync for the next line sync edge.
- R5: A line sync rising edge with no pending frame sync has no effect, and the index keeps cycling.
- R6: A restart clears the pending frame sync, so a second line sync edge in the same frame does not restart the pattern.
- R7: mode_sel_i (0 = 3-color, 1 = 4-color) is copied into the active mode only at a restart. Changes to it at other times do not alter the cycle length.
- R8: gain_idx_o and gain_o are registered. After strobe edge k+1 they show the index chosen at edge k and the gain word stored at that index before edge k+1.
- R9: When wr_en_i is high at a strobe edge, wr_data_i is stored in the gain word at wr_addr_i (0 to 3). A write does not change the index sequence.
- R10: Sync input activity that starts and ends between two strobe edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel sample strobe |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vd_i | input | 1 | Frame sync |
| hd_i | input | 1 | Line sync |
| mode_sel_i | input | 1 | Requested mode: 0 = 3-color, 1 = 4-color |
| wr_en_i | input | 1 | Gain word write enable |
| wr_addr_i | input | 2 | Gain word address |
| wr_data_i | input | 6 | Gain word data |
| gain_o | output | 6 | Selected gain word, registered |
| gain_idx_o | output | 2 | Index of the selected gain word, registered |

## Verification
The bench targets several corner cases; each list item names the case and the fault it catches.
- A line sync before any frame sync, and a second line sync in the same frame: a design that restarts on every line sync would jump back to index 0 in either case.
- A frame sync and a line sync rising at the same strobe edge: a design that treats these as ordered would restart one line early.
- A mode request mid-line: a design that switches mode immediately would change the cycle length partway through a line.
- Sync glitches between strobe edges, and writes while the pattern runs: a design that reacts to them would skip an index, or show a gain word one pixel early or late.

// File: rtl/color_gain_pkg.sv
package color_gain_pkg;
  localparam int unsigned NUM_GAINS = 4;
  localparam int unsigned GAIN_W    = 6;
  localparam int unsigned IDX_W     = $clog2(NUM_GAINS);

  typedef enum logic {
    MODE_3C = 1'b0,
    MODE_4C = 1'b1
  } cmode_e;
endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q;
  end
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import color_gain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vd_rise_i,
  input  logic             hd_rise_i,
  input  logic             mode_sel_i,
  output logic [IDX_W-1:0] idx_o,
  output cmode_e           mode_o,
  output logic             pend_o,
  output logic             restart_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  cmode_e           mode_q;
  logic             pend_q;

  assign last_idx  = (mode_q == MODE_4C) ? IDX_W'(3) : IDX_W'(2);
  // only a frame edge seen at an earlier strobe arms the restart
  assign restart_o = hd_rise_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= MODE_3C;
      pend_q <= 1'b0;
    end else begin
      if (restart_o) begin
        idx_q  <= '0;
        mode_q <= cmode_e'(mode_sel_i);
      end else if (idx_q >= last_idx) begin
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
      pend_q <= vd_rise_i | (pend_q & ~hd_rise_i);
    end
  end

  assign idx_o  = idx_q;
  assign mode_o = mode_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cs_gain_bank.sv
module cs_gain_bank
  import color_gain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [GAIN_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [GAIN_W-1:0] regs_q [NUM_GAINS];

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == IDX_W'(g))   regs_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= '0;
      idx_o  <= '0;
    end else begin
      gain_o <= regs_q[rd_idx_i];
      idx_o  <= rd_idx_i;
    end
  end
endmodule

// File: rtl/color_gain_seq.sv
module color_gain_seq
  import color_gain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vd_i,
  input  logic              hd_i,
  input  logic              mode_sel_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [GAIN_W-1:0] wr_data_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [IDX_W-1:0]  gain_idx_o
);
  logic [1:0]       rise;
  logic [IDX_W-1:0] idx;
  cmode_e           mode;
  logic             pend;
  logic             restart;

  cs_sync_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({hd_i, vd_i}),
    .rise_o (rise)
  );

  cs_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vd_rise_i  (rise[0]),
    .hd_rise_i  (rise[1]),
    .mode_sel_i (mode_sel_i),
    .idx_o      (idx),
    .mode_o     (mode),
    .pend_o     (pend),
    .restart_o  (restart)
  );

  cs_gain_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (idx),
    .gain_o    (gain_o),
    .idx_o     (gain_idx_o)
  );
endmodule

// File: rtl/color_gain_seq_chk.sv
module color_gain_seq_chk
  import color_gain_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       rise,
  input logic [IDX_W-1:0] idx,
  input cmode_e           mode,
  input logic             pend,
  input logic             restart,
  input logic [IDX_W-1:0] gain_idx_o
);
  // R4
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> idx == '0);
  // R6
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !rise[0]) |=> !pend);
  // R5
  hd_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[1] && !pend && mode == MODE_4C && idx == IDX_W'(1)) |=> idx == IDX_W'(2));
  // R2
  three_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_3C |-> idx != IDX_W'(3));
  // R2
  three_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_3C && idx == IDX_W'(2) && !restart) |=> idx == '0);
  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart |=> $stable(mode));
  // R8
  out_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> gain_idx_o == $past(idx));
endmodule

bind color_gain_seq color_gain_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rise       (rise),
  .idx        (idx),
  .mode       (mode),
  .pend       (pend),
  .restart    (restart),
  .gain_idx_o (gain_idx_o)
);

// File: tb/sim_color_gain_seq.sv
module sim_color_gain_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vd_i = 1'b0, hd_i = 1'b0, mode_sel_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [5:0] wr_data_i = '0;
  logic [5:0] gain_o;
  logic [1:0] gain_idx_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic       m_vdq, m_hdq, m_pend, m_mode;
  logic [1:0] m_idx, e_idx;
  logic [5:0] m_regs [4];
  logic [5:0] e_gain;

  always #5 clk_i = ~clk_i;

  color_gain_seq u0 (.*);

  function automatic logic [1:0] adv(input logic [1:0] i, input logic md);
    logic [1:0] last = md ? 2'd3 : 2'd2;
    return (i >= last) ? 2'd0 : i + 2'd1;
  endfunction

  task automatic chk(input string req, input logic [5:0] g, input logic [1:0] ix);
    checks++;
    if (gain_o !== g || gain_idx_o !== ix) begin
      errors++;
      $display("FAIL %s: gain=%0d idx=%0d expected gain=%0d idx=%0d", req, gain_o, gain_idx_o, g, ix);
    end
  endtask

  task automatic model_reset();
    m_vdq = 0; m_hdq = 0; m_pend = 0; m_mode = 0; m_idx = 0; e_idx = 0; e_gain = 0;
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
  endtask

  // one strobe: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input string req, input logic vd, input logic hd, input logic ms,
                     input logic we, input logic [1:0] wa, input logic [5:0] wd);
    logic vr, hr, rs;
    vd_i = vd; hd_i = hd; mode_sel_i = ms; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    vr = vd & ~m_vdq; hr = hd & ~m_hdq; rs = hr & m_pend;
    e_idx = m_idx; e_gain = m_regs[m_idx];
    if (rs) begin m_idx = 0; m_mode = ms; end
    else m_idx = adv(m_idx, m_mode);
    m_pend = vr | (m_pend & ~hr);
    if (we) m_regs[wa] = wd;
    m_vdq = vd; m_hdq = hd;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, e_gain, e_idx);
  endtask

  task automatic run(input string req, input int n, input logic vd, input logic hd, input logic ms);
    for (int i = 0; i < n; i++) cyc(req, vd, hd, ms, 1'b0, 2'd0, 6'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 reset", 6'd0, 2'd0);
    rst_ni = 1'b1;
    run("R1 R2 default words", 6, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R9 load", 0, 0, 0, 1'b1, 2'(i), 6'(11 * (i + 1)));
    run("R2 3-color", 9, 0, 0, 1);
    // line sync with nothing pending
    run("R5 hd no vd", 6, 0, 1, 1);
    run("R5 hd no vd", 4, 0, 0, 1);
    // frame then line: restart into 4-color
    run("R4 vd", 6, 1, 0, 1);
    run("R4 gap", 3, 0, 0, 1);
    cyc("R4 restart edge", 0, 1, 1, 0, 0, 0);
    cyc("R4 restart out", 0, 1, 1, 0, 0, 0);
    chk("R4 first pixel", 6'd11, 2'd0);
    run("R3 4-color", 10, 0, 1, 0);
    run("R3 4-color", 5, 0, 0, 0);
    // second line sync in the same frame
    run("R6 second hd", 6, 0, 1, 0);
    run("R6 second hd", 5, 0, 0, 0);
    // mode request mid-line has no effect
    run("R7 mode mid-line", 9, 0, 0, 0);
    // coincident syncs: no restart, pending kept
    run("R4 same edge", 6, 1, 1, 0);
    run("R4 same edge", 4, 0, 0, 0);
    run("R4 pending line", 6, 0, 1, 0);
    run("R7 3-color back", 6, 0, 0, 0);
    // glitches between strobes
    run("R10 vd glitch", 5, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      #1 vd_i = 1; #1 vd_i = 0; #1 hd_i = 1; #1 hd_i = 0;
      cyc("R10 glitch", 0, 0, 1, 0, 0, 0);
    end
    run("R10 after glitch", 6, 0, 1, 1);
    run("R10 after glitch", 3, 0, 0, 1);
    // writes while running
    for (int i = 0; i < 8; i++) cyc("R9 write mid-line", 0, 0, 1, 1'b1, 2'(i % 4), 6'(50 + i));
    // random frames
    for (int f = 0; f < 150; f++) begin
      logic ms = 1'($urandom);
      int seg = $urandom_range(0, 3);
      logic vd = (seg == 1) || (seg == 3);
      logic hd = (seg >= 2);
      int len = $urandom_range(5, 12);
      for (int i = 0; i < len; i++) begin
        logic we = ($urandom_range(0, 3) == 0);
        cyc("R2 R3 R4 R9 random", vd, hd, ms, we, 2'($urandom), 6'($urandom));
      end
      for (int i = 0; i < $urandom_range(5, 9); i++)
        cyc("R2 R3 R5 random gap", 0, 0, ms, 0, 0, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule